// File: doc/BRIEF.md
# Reset-Strapped Bus Clock Divider

This block derives a slower bus clock from the fast processor clock. The divide ratio is not programmed by software. It is strapped on the low bits of the shared data bus and captured while the reset input is held low. The supported ratios are 2, 3 and 4. A second two-bit strap on the next data bits carries the input-frequency range. That range is captured in the same way and handed on unchanged to the analog clock logic outside this block.

On the first processor clock after reset is released, the bus clock starts with a rising edge. Alongside it, the block produces a one-cycle pulse that marks each bus-clock rising edge, so synchronous logic in the processor domain can use it as an enable. The block also outputs an inverted copy of the processor clock as a status clock. Finally, it drives a peripheral reset that stays asserted for a fixed number of bus-clock cycles after the reset input deasserts.

Top module: `busclk_gen`

## Requirements
- R1: While `rst_in_n` is low, the divide code is sampled from data bits 1:0 on every processor clock edge. The value present at the last edge with reset low is kept. After release, changes on the data pins do not alter `div_code_o`.
- R2: The bus clock period is 4 processor cycles for code 00, 2 for code 10 and 3 for code 11.
- R3: Code 01 is reserved. When it is latched, the bus clock runs at divide by 4 and `cfg_err_o` is 1. For every other code, `cfg_err_o` is 0.
- R4: `freq_code_o` holds data bits 3:2 as captured under the same rule as R1 (00 low, 01 middle, 10 high, 11 unused). It is passed on unchanged.
- R5: `bclk_o` is 0 while reset is asserted. It becomes 1 at the first processor clock edge with `rst_in_n` high.
- R6: In divide-by-2 and divide-by-4, the bus clock is high for half of its period. In divide-by-3, it is high for one processor cycle and low for two.
- R7: `bclk_rise_o` is high for exactly the one processor cycle in which `bclk_o` has just risen, and at no other time.
- R8: `prst_n_o` is 0 during reset. It becomes 1 at the processor edge that starts the 17th bus-clock cycle after release (edge 1+16·N counted from release), and stays 1 until the next reset.
- R9: `stclk_o` toggles at the processor clock rate, inverted from it: it is low while `pclk_i` is high and high while `pclk_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Processor clock |
| rst_in_n | input | 1 | Active-low reset input, synchronous |
| data_i | input | DATA_W | Shared data pins carrying the straps during reset |
| bclk_o | output | 1 | Divided bus clock |
| bclk_rise_o | output | 1 | One-cycle pulse at each bus-clock rising edge |
| stclk_o | output | 1 | Processor-status clock (inverted processor clock) |
| prst_n_o | output | 1 | Active-low peripheral reset |
| div_code_o | output | 2 | Latched divide-select strap |
| freq_code_o | output | 2 | Latched input-frequency range strap |
| cfg_err_o | output | 1 | Reserved divide code was latched |

## Verification
The bench uses the default parameters: a 32-bit data bus, straps at bits 1:0 and 3:2, and a 16-cycle peripheral reset. With these values, each post-release run of 80 processor cycles covers the complete peripheral-reset window at the slowest ratio. All four divide codes are applied, including the reserved one. In each case the data pins change several times during reset and keep changing afterwards, which exercises the last-sample capture rule and the rule that later data changes are ignored.

// File: rtl/busclk_pkg.sv
// Shared definitions for the bus clock divider.
// Assumes the divide strap is two bits wide and the largest ratio is 4.
package busclk_pkg;

    localparam int MAX_RATIO = 4;
    localparam int PH_W      = $clog2(MAX_RATIO);

    typedef enum logic [1:0] {
        DIV_BY4  = 2'b00,
        DIV_RSVD = 2'b01,
        DIV_BY2  = 2'b10,
        DIV_BY3  = 2'b11
    } div_code_e;

    // Maps a strap code to the processor cycles per bus cycle; reserved falls back to 4.
    function automatic logic [2:0] ratio_of(input logic [1:0] code);
        case (code)
            DIV_BY2: ratio_of = 3'd2;
            DIV_BY3: ratio_of = 3'd3;
            default: ratio_of = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/strap_latch.sv
// Captures the divide and frequency-range straps from the data pins while
// reset is low and holds them afterwards. Assumes data_i is stable around
// the last clock edge that sees reset low.
module strap_latch
    import busclk_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DIV_LSB  = 0,
    parameter int FREQ_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    output logic [1:0]        div_code,
    output logic [1:0]        freq_code,
    output logic              cfg_err,
    output logic [2:0]        ratio
);

    // Sample both strap fields on every edge while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_code  <= data_i[DIV_LSB +: 2];
            freq_code <= data_i[FREQ_LSB +: 2];
            cfg_err   <= (data_i[DIV_LSB +: 2] == DIV_RSVD);
        end
    end

    // Translate the held code into a ratio.
    always_comb ratio = ratio_of(div_code);

    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($stable(div_code) && $stable(freq_code)));

endmodule

// File: rtl/bclk_div.sv
// Phase counter that produces the bus clock and its rising-edge pulse.
// Assumes the ratio is 2, 3 or 4 and does not change once reset is released.
// The high time is ratio/2 processor cycles, which gives 50% duty for even
// ratios and 1 high / 2 low for ratio 3.
module bclk_div
    import busclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] ratio,
    output logic       bclk,
    output logic       rise,
    output logic       rise_next
);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] ph_next;

    // Next phase, wrapping at ratio-1; a reset phase of max always wraps to 0.
    always_comb begin
        if ({1'b0, ph} >= ratio - 3'd1) ph_next = '0;
        else                            ph_next = ph + 1'b1;
        rise_next = (ph_next == '0);
    end

    // Advance the phase and register the bus clock and its edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= '1;
            bclk <= 1'b0;
            rise <= 1'b0;
        end else begin
            ph   <= ph_next;
            bclk <= ({1'b0, ph_next} < (ratio >> 1));
            rise <= rise_next;
        end
    end

    // R5
    bclk_low_in_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !bclk);

    // R7
    rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (bclk && !$past(bclk)));

    // R7
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R6
    div3_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio == 3'd3 && bclk) |=> !bclk);

endmodule

// File: rtl/prst_stretch.sv
// Holds the peripheral reset low for RST_CYC bus-clock cycles after release.
// It counts bus-clock rising edges and releases at the next rising edge.
// Assumes rise_next marks the processor edge at which each bus cycle begins.
module prst_stretch #(
    parameter int RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_next,
    output logic prst_n
);

    localparam int CNT_W = $clog2(RST_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Count bus-cycle starts and release once RST_CYC full cycles have passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            prst_n <= 1'b0;
        end else if (rise_next && !prst_n) begin
            if (cnt == CNT_W'(RST_CYC)) prst_n <= 1'b1;
            else                        cnt    <= cnt + 1'b1;
        end
    end

    // R8
    prst_in_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !prst_n);

    // R8
    prst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prst_n |=> prst_n);

endmodule

// File: rtl/busclk_gen.sv
// Top of the reset-strapped bus clock divider. Latches the straps, divides
// the processor clock, stretches the peripheral reset and forwards an
// inverted processor clock as the status clock. Assumes rst_in_n is
// synchronous to pclk_i.
module busclk_gen
    import busclk_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DIV_LSB  = 0,
    parameter int FREQ_LSB = 2,
    parameter int RST_CYC  = 16
) (
    input  logic              pclk_i,
    input  logic              rst_in_n,
    input  logic [DATA_W-1:0] data_i,
    output logic              bclk_o,
    output logic              bclk_rise_o,
    output logic              stclk_o,
    output logic              prst_n_o,
    output logic [1:0]        div_code_o,
    output logic [1:0]        freq_code_o,
    output logic              cfg_err_o
);

    logic [2:0] ratio;
    logic       rise_next;

    strap_latch #(
        .DATA_W  (DATA_W),
        .DIV_LSB (DIV_LSB),
        .FREQ_LSB(FREQ_LSB)
    ) u_strap (
        .clk      (pclk_i),
        .rst_n    (rst_in_n),
        .data_i   (data_i),
        .div_code (div_code_o),
        .freq_code(freq_code_o),
        .cfg_err  (cfg_err_o),
        .ratio    (ratio)
    );

    bclk_div u_div (
        .clk      (pclk_i),
        .rst_n    (rst_in_n),
        .ratio    (ratio),
        .bclk     (bclk_o),
        .rise     (bclk_rise_o),
        .rise_next(rise_next)
    );

    prst_stretch #(
        .RST_CYC(RST_CYC)
    ) u_prst (
        .clk      (pclk_i),
        .rst_n    (rst_in_n),
        .rise_next(rise_next),
        .prst_n   (prst_n_o)
    );

    // Status clock: processor clock delayed by half a cycle through inversion.
    assign stclk_o = ~pclk_i;

    // R3
    err_falls_back_chk: assert property (@(posedge pclk_i) disable iff (!rst_in_n)
        cfg_err_o |-> (ratio == 3'd4));

endmodule

// File: tb/tb_busclk_gen.sv
module tb_busclk_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data = 32'h0;

    logic bclk, rise, stclk, prst_n, err;
    logic [1:0] divc, frc;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    int e = 0;
    int m_div = 0;
    int m_fr = 0;
    int rise_cnt = 0;

    always #4 clk = ~clk;

    busclk_gen dut (
        .pclk_i     (clk),
        .rst_in_n   (rst_n),
        .data_i     (data),
        .bclk_o     (bclk),
        .bclk_rise_o(rise),
        .stclk_o    (stclk),
        .prst_n_o   (prst_n),
        .div_code_o (divc),
        .freq_code_o(frc),
        .cfg_err_o  (err)
    );

    // Behavioural reference state, updated at each rising edge.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            e = 0;
            m_div = int'(data[1:0]);
            m_fr  = int'(data[3:2]);
        end else begin
            e = e + 1;
        end
    end

    function automatic int ratio_m(int code);
        if (code == 3) return 3;
        if (code == 2) return 2;
        return 4;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model, called after a falling edge.
    task automatic compare();
        int n, p, eb, er, ep;
        n = ratio_m(m_div);
        if (e == 0) begin
            eb = 0; er = 0; ep = 0;
        end else begin
            p  = (e - 1) % n;
            eb = (p < n / 2) ? 1 : 0;
            er = (p == 0) ? 1 : 0;
            ep = (e >= 1 + 16 * n) ? 1 : 0;
        end
        if (e <= 1) check("R5", int'(bclk), eb);
        else if (n == 3) check("R2", int'(bclk), eb);
        else check("R6", int'(bclk), eb);
        check("R7", int'(rise), er);
        check("R8", int'(prst_n), ep);
        check("R1", int'(divc), m_div);
        check("R4", int'(frc), m_fr);
        check("R3", int'(err), (m_div == 1) ? 1 : 0);
        if (rst_n && rise) rise_cnt++;
    endtask

    task automatic scenario(logic [3:0] strap, logic [31:0] junk);
        int n;
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); compare();
            data = junk ^ (32'h5 * i);
        end
        @(negedge clk); compare();
        data = {junk[31:4], strap};
        @(negedge clk); compare();
        rst_n = 1'b1;
        data = ~data;
        rise_cnt = 0;
        // R9: status clock is low during the processor-clock high phase
        @(posedge clk); #2;
        check("R9", int'(stclk), 0);
        @(negedge clk); #1;
        check("R9", int'(stclk), 1);
        compare();
        for (int i = 1; i < 80; i++) begin
            @(negedge clk); compare();
            data = data + 32'h9;
        end
        // R2: number of bus cycles in 80 processor cycles
        n = ratio_m(int'(strap[1:0]));
        check("R2", rise_cnt, (80 + n - 1) / n);
    endtask

    initial begin
        scenario(4'b0011, 32'hA5A5_0F0C);
        scenario(4'b0110, 32'h1234_5671);
        scenario(4'b1000, 32'hFFFF_FFF3);
        scenario(4'b1101, 32'h0000_0002);
        scenario(4'b0111, 32'hCAFE_0000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cyc > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule